// File: doc/BRIEF.md
# Zero-Suppressing Channel Word Packer

The packer takes the per-channel results of one triggered integration window and emits a stream of 32-bit words: one word per channel whose discriminator fired. Each window result holds an 8-bit charge (ADC) value, an 8-bit time (TDC) value and a discriminator flag for every channel. Channels without a hit are dropped, so the readout carries little beyond the channels that saw signal. A bypass input turns suppression off for one event, and every channel is then reported. Pedestal runs use this mode.

A trigger is accepted with a valid/ready handshake. At that moment the whole window is copied into the block, so the front end may reuse its buffers at once. The block then walks the captured channels from the lowest number upward. It keeps an 8-bit event counter and writes the current event number into every word. Output words leave over a valid/ready stream, and the last word of an event is flagged with `out_last`. An event in which no channel fired still produces exactly one marker word, so the consumer sees every trigger.

The controller has three states. `S_IDLE` accepts triggers. `S_SCAN` emits the hit channels. `S_EMPTY` emits the marker for an event with no hits. The transitions are:
- IDLE_TO_SCAN: trigger accepted with at least one channel to report.
- IDLE_TO_EMPTY: trigger accepted with nothing to report.
- SCAN_STAY: a non-final word is loaded, or the output slot is busy.
- SCAN_TO_IDLE: the final word of the event is loaded.
- EMPTY_TO_IDLE: the marker is loaded.

The event counter steps on SCAN_TO_IDLE and on EMPTY_TO_IDLE.

Top module: `zs_packer`

## Requirements
- R1: A data word is laid out as ADC value in bits 7:0, TDC value in bits 15:8, channel number in bits 22:16, discriminator flag in bit 23 and event number in bits 31:24.
- R2: With bypass low at the trigger, a channel whose discriminator flag is 0 produces no word.
- R3: Within an event, words appear in strictly ascending channel order.
- R4: `out_last` is 1 on the final word of each event and 0 on every other word.
- R5: An event with nothing to report produces exactly one marker word, equal to {event number, 1'b0, 7'h7F, 16'h0000}, with `out_last` = 1.
- R6: The first event after reset carries number 0. Each accepted trigger advances the number by one, and 255 wraps to 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and keeps `out_data` and `out_last` unchanged. No word is lost, duplicated or reordered.
- R8: With bypass high at the trigger, every channel 0..NCH-1 produces a word. Bit 23 of each word carries that channel's real discriminator flag.
- R9: `trig_ready` is 1 only in `S_IDLE`. It drops in the cycle after a trigger is accepted. A `trig_valid` pulse while `trig_ready` is 0 is ignored and produces no words.
- R10: After reset, `out_valid` is 0 and `trig_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | A window result is offered |
| trig_ready | output | 1 | Block can accept a window (idle) |
| bypass | input | 1 | Report every channel for this event; sampled with the trigger |
| win_adc | input | NCH*8 | ADC value of channel i in bits 8i+7:8i |
| win_tdc | input | NCH*8 | TDC value of channel i in bits 8i+7:8i |
| win_disc | input | NCH | Discriminator flag of channel i in bit i |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A word is presented |
| out_data | output | 32 | Packed word or empty-event marker |
| out_last | output | 1 | Word is the last of its event |

## Verification
Faults in the captured pending mask show up on the first event as missing, repeated or out-of-order channel numbers. An error in the single-remaining-hit detection shows up on the same event as `out_last` on the wrong word. It also shows up as a second event's words carrying the first event's number, because the counter steps only on the final load. A wrong counter becomes visible in bits 31:24 of the next event's first word, and the wrap at 255 only after 256 triggers, so the bench drives more than that. A hold fault in the output stage appears in the first cycle the stream is stalled, which is why the ready input is varied pseudo-randomly.

// File: rtl/zs_pkg.sv
package zs_pkg;

    // Fixed field widths of the packed output word
    localparam int ADC_W  = 8;
    localparam int TDC_W  = 8;
    localparam int CH_W   = 7;
    localparam int EVT_W  = 8;
    localparam int WORD_W = ADC_W + TDC_W + CH_W + 1 + EVT_W;

    // Channel code reserved for the empty-event marker
    localparam logic [CH_W-1:0] MARK_CH = 7'h7F;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_EMPTY = 2'd2
    } zs_state_t;

    function automatic logic [WORD_W-1:0] zs_pack(
        input logic [EVT_W-1:0] evt,
        input logic             disc,
        input logic [CH_W-1:0]  ch,
        input logic [TDC_W-1:0] tdc,
        input logic [ADC_W-1:0] adc
    );
        return {evt, disc, ch, tdc, adc};
    endfunction

    function automatic logic [WORD_W-1:0] zs_marker(input logic [EVT_W-1:0] evt);
        return {evt, 1'b0, MARK_CH, {(TDC_W+ADC_W){1'b0}}};
    endfunction

endpackage

// File: rtl/zs_window_reg.sv
// Captures one window result and keeps the set of channels still to report.
module zs_window_reg #(
    parameter int NCH   = 32,
    parameter int VAL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 bypass,
    input  logic [NCH*VAL_W-1:0] adc_in,
    input  logic [NCH*VAL_W-1:0] tdc_in,
    input  logic [NCH-1:0]       disc_in,
    input  logic [NCH-1:0]       clr,
    output logic [NCH*VAL_W-1:0] adc_q,
    output logic [NCH*VAL_W-1:0] tdc_q,
    output logic [NCH-1:0]       disc_q,
    output logic [NCH-1:0]       pend_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_q  <= '0;
            tdc_q  <= '0;
            disc_q <= '0;
            pend_q <= '0;
        end else if (load) begin
            adc_q  <= adc_in;
            tdc_q  <= tdc_in;
            disc_q <= disc_in;
            // bypass reports every channel; otherwise only fired ones
            pend_q <= bypass ? '1 : disc_in;
        end else begin
            pend_q <= pend_q & ~clr;
        end
    end

endmodule

// File: rtl/zs_pick.sv
// Lowest pending channel and whether it is the only one left.
module zs_pick #(
    parameter int NCH   = 32,
    parameter int IDX_W = 5
) (
    input  logic [NCH-1:0]   mask,
    output logic [IDX_W-1:0] idx,
    output logic             single
);

    localparam logic [NCH-1:0] ONE = NCH'(1);

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end

    // clearing the lowest set bit leaves nothing: at most one bit set
    assign single = ((mask & (mask - ONE)) == '0);

endmodule

// File: rtl/zs_out_stage.sv
// One-word output register; holds its word until the consumer takes it.
module zs_out_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              last_in,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] data,
    output logic              last,
    output logic              free
);

    assign free = !valid || ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            last  <= 1'b0;
        end else begin
            if (load) begin
                valid <= 1'b1;
                data  <= word_in;
                last  <= last_in;
            end else if (ready) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/zs_packer.sv
module zs_packer #(
    parameter int NCH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_valid,
    output logic                 trig_ready,
    input  logic                 bypass,
    input  logic [NCH*8-1:0]     win_adc,
    input  logic [NCH*8-1:0]     win_tdc,
    input  logic [NCH-1:0]       win_disc,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [31:0]          out_data,
    output logic                 out_last
);
    import zs_pkg::*;

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [NCH-1:0] ONE = NCH'(1);

    initial begin
        if (NCH < 1 || NCH > 127) $error("NCH must lie in 1..127");
    end

    zs_state_t state_q, state_d;

    logic                 take;
    logic [NCH*ADC_W-1:0] adc_q;
    logic [NCH*TDC_W-1:0] tdc_q;
    logic [NCH-1:0]       disc_q;
    logic [NCH-1:0]       pend_q;
    logic [NCH-1:0]       clr;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_single;
    logic                 slot_free;
    logic                 load;
    logic [WORD_W-1:0]    load_word;
    logic                 load_last;
    logic                 evt_step;
    logic [EVT_W-1:0]     evt_q;
    logic                 any_report;

    assign trig_ready = (state_q == S_IDLE);
    assign take       = trig_valid && trig_ready;
    assign any_report = bypass || (|win_disc);

    zs_window_reg #(.NCH(NCH), .VAL_W(8)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take),
        .bypass (bypass),
        .adc_in (win_adc),
        .tdc_in (win_tdc),
        .disc_in(win_disc),
        .clr    (clr),
        .adc_q  (adc_q),
        .tdc_q  (tdc_q),
        .disc_q (disc_q),
        .pend_q (pend_q)
    );

    zs_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
        .mask  (pend_q),
        .idx   (pick_idx),
        .single(pick_single)
    );

    zs_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .word_in(load_word),
        .last_in(load_last),
        .ready  (out_ready),
        .valid  (out_valid),
        .data   (out_data),
        .last   (out_last),
        .free   (slot_free)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-cycle controls
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        load_word = '0;
        load_last = 1'b0;
        clr       = '0;
        evt_step  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (take) state_d = any_report ? S_SCAN : S_EMPTY;
            end
            S_SCAN: begin
                if (slot_free) begin
                    load      = 1'b1;
                    load_word = zs_pack(evt_q, disc_q[pick_idx], CH_W'(pick_idx),
                                        tdc_q[pick_idx*TDC_W +: TDC_W],
                                        adc_q[pick_idx*ADC_W +: ADC_W]);
                    load_last = pick_single;
                    clr       = ONE << pick_idx;
                    if (pick_single) begin
                        state_d  = S_IDLE;
                        evt_step = 1'b1;
                    end
                end
            end
            S_EMPTY: begin
                if (slot_free) begin
                    load      = 1'b1;
                    load_word = zs_marker(evt_q);
                    load_last = 1'b1;
                    state_d   = S_IDLE;
                    evt_step  = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // event number: steps once per completed event, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n)        evt_q <= '0;
        else if (evt_step) evt_q <= evt_q + EVT_W'(1);
    end

endmodule

// File: rtl/zs_packer_chk.sv
module zs_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_valid,
    input logic        trig_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last
);

    logic       hs;
    logic       in_evt;
    logic       have_done;
    logic [6:0] prev_ch;
    logic [7:0] done_evt;

    assign hs = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_evt    <= 1'b0;
            have_done <= 1'b0;
            prev_ch   <= '0;
            done_evt  <= '0;
        end else if (hs) begin
            if (out_last) begin
                in_evt    <= 1'b0;
                have_done <= 1'b1;
                done_evt  <= out_data[31:24];
            end else begin
                in_evt    <= 1'b1;
                prev_ch   <= out_data[22:16];
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7

    AST_ONE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && trig_ready |=> !trig_ready); // R9

    AST_MARKER_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data[22:16] == 7'h7F |-> out_last && out_data[23:0] == 24'h7F0000); // R5

    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hs && !in_evt && have_done |-> out_data[31:24] == done_evt + 8'd1); // R6

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        hs && in_evt |-> out_data[22:16] > prev_ch); // R3

endmodule

bind zs_packer zs_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_valid(trig_valid),
    .trig_ready(trig_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/sim_zs_packer.sv
`timescale 1ns/1ps
module sim_zs_packer;

    localparam int NCH = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_valid = 1'b0;
    logic             trig_ready;
    logic             bypass = 1'b0;
    logic [NCH*8-1:0] win_adc;
    logic [NCH*8-1:0] win_tdc;
    logic [NCH-1:0]   win_disc = '0;
    logic             out_ready = 1'b1;
    logic             out_valid;
    logic [31:0]      out_data;
    logic             out_last;

    logic [7:0] adc_v [NCH];
    logic [7:0] tdc_v [NCH];

    int errors = 0;
    int checks = 0;
    int ready_mode = 0;      // 0: always ready, 1: pseudo-random, 2: never
    string cur_tag = "R1";
    logic [32:0] exp_q [$];
    logic [7:0]  exp_evt = 8'd0;
    logic [15:0] lfsr = 16'hACE1;
    logic        stall_prev = 1'b0;
    logic [31:0] data_prev = '0;
    logic        last_prev = 1'b0;
    logic        running = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            win_adc[i*8 +: 8] = adc_v[i];
            win_tdc[i*8 +: 8] = tdc_v[i];
        end
    end

    zs_packer #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
        .bypass(bypass), .win_adc(win_adc), .win_tdc(win_tdc), .win_disc(win_disc),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // stream monitor: sets ready, checks hold, compares every accepted word
    always @(negedge clk) begin
        if (running) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : lfsr[0];
            if (stall_prev)
                check(out_valid && out_data == data_prev && out_last == last_prev, "R7",
                      {out_last, out_data}, {last_prev, data_prev});
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, {out_last, out_data}, 33'h0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check({out_last, out_data} == e, cur_tag, {out_last, out_data}, e);
                end
            end
            stall_prev = out_valid && !out_ready;
            data_prev  = out_data;
            last_prev  = out_last;
        end
    end

    task automatic set_window(input logic [NCH-1:0] disc, input int seed);
        for (int i = 0; i < NCH; i++) begin
            adc_v[i] = 8'((i * 37 + seed * 11 + 5) & 255);
            tdc_v[i] = 8'((i * 91 + seed * 7 + 200) & 255);
        end
        win_disc = disc;
    endtask

    task automatic push_expect(input bit byp);
        int last_ch;
        last_ch = -1;
        for (int i = 0; i < NCH; i++) if (byp || win_disc[i]) last_ch = i;
        if (last_ch < 0) begin
            exp_q.push_back({1'b1, exp_evt, 1'b0, 7'h7F, 16'h0000});   // R5 marker
        end else begin
            for (int i = 0; i < NCH; i++)
                if (byp || win_disc[i])
                    exp_q.push_back({(i == last_ch), exp_evt, win_disc[i], 7'(i), tdc_v[i], adc_v[i]});
        end
        exp_evt = exp_evt + 8'd1;
    endtask

    task automatic fire(input bit byp);
        @(negedge clk);
        while (!trig_ready) @(negedge clk);
        bypass = byp;
        push_expect(byp);
        trig_valid = 1'b1;
        @(negedge clk);
        trig_valid = 1'b0;
        bypass = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n;
        n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, tag, 33'(exp_q.size()), 33'h0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R10", 33'(out_valid), 33'h0);
        check(trig_ready == 1'b1, "R10", 33'(trig_ready), 33'h1);
    endtask

    task automatic t_sparse;   // R1 R2 R3 R4
        cur_tag = "R2";
        set_window(32'h8000_1025, 1);
        fire(1'b0);
        drain("R2");
        cur_tag = "R1";
        set_window(32'h0000_0001, 2);
        fire(1'b0);
        drain("R1");
    endtask

    task automatic t_all_hits;   // R3 R4
        cur_tag = "R3";
        set_window('1, 3);
        fire(1'b0);
        drain("R3");
        cur_tag = "R4";
        set_window(32'h8000_0000, 4);
        fire(1'b0);
        drain("R4");
    endtask

    task automatic t_empty;
        cur_tag = "R5";
        set_window('0, 5);
        fire(1'b0);
        drain("R5");
    endtask

    task automatic t_bypass;
        cur_tag = "R8";
        set_window(32'h0101_0240, 6);
        fire(1'b1);
        drain("R8");
        set_window('0, 7);
        fire(1'b1);
        drain("R8");
    endtask

    task automatic t_backpressure;
        cur_tag = "R7";
        ready_mode = 1;
        set_window(32'hF0F0_3C3C, 8);  fire(1'b0);
        set_window('0, 9);             fire(1'b0);
        set_window(32'h0000_FFFF, 10); fire(1'b1);
        drain("R7");
        ready_mode = 0;
    endtask

    task automatic t_busy_trigger;
        cur_tag = "R9";
        ready_mode = 2;
        set_window(32'h0000_00FF, 11);
        fire(1'b0);
        repeat (3) @(negedge clk);
        check(trig_ready == 1'b0, "R9", 33'(trig_ready), 33'h0);
        set_window('1, 12);
        trig_valid = 1'b1;          // ignored: block is busy
        @(negedge clk);
        trig_valid = 1'b0;
        ready_mode = 0;
        drain("R9");
        check(trig_ready == 1'b1, "R9", 33'(trig_ready), 33'h1);
    endtask

    task automatic t_wrap;
        cur_tag = "R6";
        set_window('0, 13);
        for (int k = 0; k < 260; k++) fire(1'b0);
        drain("R6");
        set_window(32'h0000_0002, 14);
        fire(1'b0);
        drain("R6");
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin adc_v[i] = '0; tdc_v[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        running = 1'b1;
        t_sparse();
        t_all_hits();
        t_empty();
        t_bypass();
        t_backpressure();
        t_busy_trigger();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule